// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches the external interrupt pins of a small 8-bit controller and turns each one into an interrupt request and a readable status flag. Every line runs its pin through a two-flop synchroniser. The synchronised value is captured only on a machine-cycle strobe, and only while the line's enable bit is set. A per-line trigger bit selects how the line reacts:
- In level mode, the flag follows the captured pin value and nothing is latched.
- In edge mode, a high sample followed by a low sample sets a flag. That flag stays set until the CPU takes the vector.

The vector-taken acknowledge opens a service window. While the window is open the request is masked. In edge mode, new falling edges are also discarded during the window. The CPU's return strobe closes the window. Separately, the CPU can suppress the request for one machine cycle with a hold input. This models the rule that one instruction runs after a return before the line can interrupt again.

One instance serves all lines, and the default is two. A packed status vector carries the trigger and flag bits of every line.

Top module: `ext_irq_detector`

## Requirements
- R1: A pin value reaches the sampled state only through a two-flop synchroniser and only on a clock where `mc_strobe_i` is 1 and the line's enable is 1. While a line's enable is 0, its `req_o` bit is 0, and in level mode its `flag_o` bit is 0.
- R2: With trigger bit 0 (level mode), the `flag_o` bit is 1 exactly while the last sample is 0. The flag drops when a high sample arrives, with nothing latched.
- R3: In level mode, a pin that returns high before the acknowledge leaves both the flag and the request at 0.
- R4: With trigger bit 1 (edge mode), a sample of 0 that directly follows a sample of 1 sets the flag. The flag stays set when the pin goes high again.
- R5: An acknowledge pulse on a line clears its edge flag and opens that line's service window. While the window is open, `req_o` is 0 in both modes, and falling edges in edge mode are discarded.
- R6: A return pulse closes the window. A fresh edge after that needs a high sample and then a low sample taken after the return, so a pin held low through the return raises nothing.
- R7: While a line's hold bit is 1, its `req_o` is 0. In level mode, a pin still low after the return raises `req_o` as soon as hold drops.
- R8: `status_o` bit 2k is line k's trigger bit and bit 2k+1 is line k's flag.
- R9: Reset clears all flags and closes all windows. It sets the stored sample and the synchroniser to 1, so a pin held high at power-up gives no edge.
- R10: Lines are independent: stimulus on one line never changes another line's flag or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | N_LINES | Raw interrupt pins, active low |
| mc_strobe_i | input | 1 | One-clock pulse per machine cycle |
| enable_i | input | N_LINES | Per-line interrupt enable |
| trig_i | input | N_LINES | Per-line trigger: 0 level, 1 falling edge |
| ack_i | input | N_LINES | Vector-taken pulse per line |
| reti_i | input | N_LINES | Return-from-service pulse per line |
| hold_i | input | N_LINES | Request suppression after return |
| flag_o | output | N_LINES | Per-line status flag |
| req_o | output | N_LINES | Per-line interrupt request |
| status_o | output | 2*N_LINES | Packed trigger and flag bits per line |

## Verification
The hardest state to reach is the edge line's service window with pin activity inside it. It matters most when the pin is left low across the return, because a design that keeps detecting edges or forgets the prior sample would raise a false request there. The bench acknowledges a fresh edge and toggles the pin during the window. It then holds the pin low through the return, and only afterwards gives a clean high-then-low sequence. The main stimulus sweeps every three-sample pin pattern on both lines at once, with complementary patterns, under all four trigger combinations. The expected flag is computed from the pattern alone.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  // A falling transition between two successive machine-cycle samples.
  function automatic logic is_fall(input logic prev_s, input logic cur_s);
    return prev_s & ~cur_s;
  endfunction

  // Request output: flag gated by enable, the service window and hold.
  function automatic logic gate_req(input logic en, input logic flag,
                                    input logic win, input logic hold);
    return en & flag & ~win & ~hold;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b1;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_line.sv
module irq_line
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s_i,
  input  logic strobe_i,
  input  logic en_i,
  input  logic trig_i,
  input  logic ack_i,
  input  logic reti_i,
  input  logic hold_i,
  output logic flag_o,
  output logic req_o,
  output logic sample_o,
  output logic fall_o,
  output logic window_o
);
  logic  smp_q;
  logic  edge_q;
  logic  win_q;
  logic  take;
  trig_e trig;

  assign trig   = trig_e'(trig_i);
  assign take   = strobe_i & en_i;
  assign fall_o = take & is_fall(smp_q, pin_s_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= 1'b1;
    else if (take) smp_q <= pin_s_i;
  end

  // Acknowledge wins over a coincident edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_q <= 1'b0;
    else if (ack_i) edge_q <= 1'b0;
    else if (fall_o && trig == TRIG_EDGE && !win_q) edge_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else if (ack_i) win_q <= 1'b1;
    else if (reti_i) win_q <= 1'b0;
  end

  always_comb begin
    if (trig == TRIG_EDGE) flag_o = edge_q;
    else flag_o = en_i & ~smp_q;
  end

  assign req_o    = gate_req(en_i, flag_o, win_q, hold_i);
  assign sample_o = smp_q;
  assign window_o = win_q;
endmodule

// File: rtl/ext_irq_detector.sv
module ext_irq_detector #(
  parameter int N_LINES     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_LINES-1:0]   pin_i,
  input  logic                 mc_strobe_i,
  input  logic [N_LINES-1:0]   enable_i,
  input  logic [N_LINES-1:0]   trig_i,
  input  logic [N_LINES-1:0]   ack_i,
  input  logic [N_LINES-1:0]   reti_i,
  input  logic [N_LINES-1:0]   hold_i,
  output logic [N_LINES-1:0]   flag_o,
  output logic [N_LINES-1:0]   req_o,
  output logic [2*N_LINES-1:0] status_o
);
  localparam int STW = 2 * N_LINES;

  // Internal events brought out for the checker.
  logic [N_LINES-1:0] pin_sync_w;
  logic [N_LINES-1:0] sample_w;
  logic [N_LINES-1:0] fall_w;
  logic [N_LINES-1:0] window_w;

  generate
    for (genvar k = 0; k < N_LINES; k++) begin : g_line
      irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i[k]),
        .q_o   (pin_sync_w[k])
      );
      irq_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s_i  (pin_sync_w[k]),
        .strobe_i (mc_strobe_i),
        .en_i     (enable_i[k]),
        .trig_i   (trig_i[k]),
        .ack_i    (ack_i[k]),
        .reti_i   (reti_i[k]),
        .hold_i   (hold_i[k]),
        .flag_o   (flag_o[k]),
        .req_o    (req_o[k]),
        .sample_o (sample_w[k]),
        .fall_o   (fall_w[k]),
        .window_o (window_w[k])
      );
    end
  endgenerate

  always_comb begin
    status_o = '0;
    for (int k = 0; k < N_LINES; k++) begin
      status_o[2*k]   = trig_i[k];
      status_o[2*k+1] = flag_o[k];
    end
  end

  logic unused_stw;
  assign unused_stw = (STW == 0);
endmodule

// File: rtl/irq_detector_checker.sv
module irq_detector_checker #(
  parameter int N_LINES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mc_strobe_i,
  input logic [N_LINES-1:0] enable_i,
  input logic [N_LINES-1:0] trig_i,
  input logic [N_LINES-1:0] ack_i,
  input logic [N_LINES-1:0] reti_i,
  input logic [N_LINES-1:0] hold_i,
  input logic [N_LINES-1:0] flag_o,
  input logic [N_LINES-1:0] req_o,
  input logic [N_LINES-1:0] sample_w,
  input logic [N_LINES-1:0] fall_w,
  input logic [N_LINES-1:0] window_w
);
  generate
    for (genvar k = 0; k < N_LINES; k++) begin : g_chk
      p_sample_on_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mc_strobe_i && enable_i[k]) |=> $stable(sample_w[k]));
      p_no_req_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i[k] |-> !req_o[k]);
      p_level_unlatched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_i[k] && sample_w[k]) |-> !flag_o[k]);
      p_edge_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i[k] && flag_o[k] && !ack_i[k]) |=> (flag_o[k] || !trig_i[k]));
      p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i[k] && ack_i[k]) |=> (!flag_o[k] || !trig_i[k]));
      p_window_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        window_w[k] |-> !req_o[k]);
      p_window_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i[k] |=> window_w[k]);
      p_reti_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i[k] && !ack_i[k]) |=> !window_w[k]);
      p_hold_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i[k] |-> !req_o[k]);
      p_fall_needs_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_w[k] |-> (mc_strobe_i && enable_i[k] && sample_w[k]));
    end
  endgenerate
endmodule

bind ext_irq_detector irq_detector_checker #(.N_LINES(N_LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mc_strobe_i (mc_strobe_i),
  .enable_i    (enable_i),
  .trig_i      (trig_i),
  .ack_i       (ack_i),
  .reti_i      (reti_i),
  .hold_i      (hold_i),
  .flag_o      (flag_o),
  .req_o       (req_o),
  .sample_w    (sample_w),
  .fall_w      (fall_w),
  .window_w    (window_w)
);

// File: tb/test_ext_irq_detector.sv
`timescale 1ns/1ps
module test_ext_irq_detector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin_i = 2'b11;
  logic       mc_strobe_i = 1'b0;
  logic [1:0] enable_i = 2'b00;
  logic [1:0] trig_i = 2'b00;
  logic [1:0] ack_i = 2'b00;
  logic [1:0] reti_i = 2'b00;
  logic [1:0] hold_i = 2'b00;
  logic [1:0] flag_o;
  logic [1:0] req_o;
  logic [3:0] status_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ext_irq_detector i_ext_irq_detector (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .mc_strobe_i(mc_strobe_i),
    .enable_i(enable_i), .trig_i(trig_i), .ack_i(ack_i), .reti_i(reti_i),
    .hold_i(hold_i), .flag_o(flag_o), .req_o(req_o), .status_o(status_o)
  );

  always #10 clk = ~clk;

  // Machine-cycle strobe: one clock high out of every three.
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt = (cnt == 2) ? 0 : cnt + 1;
      mc_strobe_i = (cnt == 2);
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_mc(input int n);
    repeat (3*n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_ack(input logic [1:0] m);
    @(negedge clk); ack_i = m;
    @(negedge clk); ack_i = 2'b00;
    #1;
  endtask

  task automatic pulse_reti(input logic [1:0] m);
    @(negedge clk); reti_i = m;
    @(negedge clk); reti_i = 2'b00;
    #1;
  endtask

  function automatic logic exp_edge(input logic [2:0] p);
    return p != 3'b111;   // any low sample after the idle high is a fall
  endfunction

  function automatic logic exp_lvl(input logic [2:0] p);
    return ~p[0];
  endfunction

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset flags", {6'd0, flag_o}, 8'd0);
    chk("R9 reset req", {6'd0, req_o}, 8'd0);
    rst_n = 1'b1;

    // R9: pin high from power-up in edge mode gives no edge.
    trig_i = 2'b11; enable_i = 2'b11;
    wait_mc(4);
    chk("R9 no false edge", {6'd0, flag_o}, 8'd0);

    // R1: disabled level line ignores a low pin, enabling samples it.
    trig_i = 2'b00; enable_i = 2'b01; pin_i = 2'b00;
    wait_mc(3);
    chk("R1 disabled flag", {7'd0, flag_o[1]}, 8'd0);
    chk("R1 disabled req", {7'd0, req_o[1]}, 8'd0);
    chk("R2 level low", {7'd0, flag_o[0]}, 8'd1);
    enable_i = 2'b11;
    wait_mc(3);
    chk("R1 enabled flag", {7'd0, flag_o[1]}, 8'd1);

    // R3: level pin released before acknowledge.
    pin_i = 2'b11;
    wait_mc(3);
    chk("R3 flag gone", {6'd0, flag_o}, 8'd0);
    chk("R3 req gone", {6'd0, req_o}, 8'd0);

    // R7: level low held across the service routine and return.
    pin_i = 2'b10;
    wait_mc(3);
    chk("R2 level req", {7'd0, req_o[0]}, 8'd1);
    pulse_ack(2'b01);
    chk("R5 window masks level", {7'd0, req_o[0]}, 8'd0);
    chk("R2 flag during window", {7'd0, flag_o[0]}, 8'd1);
    @(negedge clk); reti_i = 2'b01; hold_i = 2'b01;
    @(negedge clk); reti_i = 2'b00;
    #1;
    chk("R7 hold masks", {7'd0, req_o[0]}, 8'd0);
    hold_i = 2'b00;
    #1;
    chk("R7 request after hold", {7'd0, req_o[0]}, 8'd1);
    pin_i = 2'b11;
    wait_mc(3);

    // R5/R6: edge window with pin activity, pin held low through return.
    trig_i = 2'b01;
    pin_i = 2'b10;
    wait_mc(3);
    chk("R4 edge set", {7'd0, flag_o[0]}, 8'd1);
    chk("R10 other line quiet", {7'd0, flag_o[1]}, 8'd0);
    pulse_ack(2'b01);
    chk("R5 ack clears", {7'd0, flag_o[0]}, 8'd0);
    pin_i = 2'b11; wait_mc(3);
    pin_i = 2'b10; wait_mc(3);
    chk("R5 edge ignored in window", {7'd0, flag_o[0]}, 8'd0);
    chk("R5 req masked", {7'd0, req_o[0]}, 8'd0);
    pulse_reti(2'b01);
    wait_mc(3);
    chk("R6 low through return", {7'd0, flag_o[0]}, 8'd0);
    pin_i = 2'b11; wait_mc(3);
    pin_i = 2'b10; wait_mc(3);
    chk("R6 fresh edge", {7'd0, flag_o[0]}, 8'd1);
    chk("R6 fresh req", {7'd0, req_o[0]}, 8'd1);

    // Sweep: every trigger combination and every 3-sample pattern.
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 8; p++) begin
        logic [2:0] p0;
        logic [2:0] p1;
        logic e0;
        logic e1;
        p0 = 3'(p);
        p1 = 3'(7 - p);
        pin_i = 2'b11;
        trig_i = 2'(m);
        wait_mc(3);
        pulse_ack(2'b11);
        pulse_reti(2'b11);
        for (int i = 2; i >= 0; i--) begin
          pin_i = {p1[i], p0[i]};
          wait_mc(3);
        end
        e0 = trig_i[0] ? exp_edge(p0) : exp_lvl(p0);
        e1 = trig_i[1] ? exp_edge(p1) : exp_lvl(p1);
        chk(trig_i[0] ? "R4 sweep flag0" : "R2 sweep flag0", {7'd0, flag_o[0]}, {7'd0, e0});
        chk(trig_i[1] ? "R4 sweep flag1" : "R2 sweep flag1", {7'd0, flag_o[1]}, {7'd0, e1});
        chk("R10 sweep req", {6'd0, req_o}, {6'd0, e1, e0});
        chk("R8 status", {4'd0, status_o}, {4'd0, e1, trig_i[1], e0, trig_i[0]});
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule